// File: doc/BRIEF.md
# Fault-checked ladder modular exponentiator

This block raises a base to an odd exponent modulo a modulus with a constant-pattern ladder. It returns two neighbouring powers, the exponent minus one and the exponent itself, each with a mask value added modulo the modulus. The caller can later remove the mask once it trusts the result. Every ladder step performs the same two products in the same order, whatever the exponent bit is. A single shared shift-and-add modular multiplier computes all products, so the run time depends only on the parameters.

The loop cannot start from a bit-by-bit scan of the top bit. The top exponent bit is taken as 1 and consumed by the set-up, and the lowest bit is consumed by a fixed closing step. While the run proceeds, a shadow copy of the exponent and an independent iteration count are kept. At the end they are compared with the working exponent and the loop index. If any comparison fails, or the exponent was not a legal input, the block raises an error flag and drives zero results instead of the powers. A caller pulses `start` and waits for the one-cycle `done`. The results and `error` then stay valid until the next accepted start.

Top module: `ladder_modexp`

## Requirements
- R1: After a synchronous active-low reset, `done`, `error`, `res_lo` and `res_hi` are all 0.
- R2: For a legal input (exponent bit 0 set, exponent bit EW-1 set, modulus at least 2, mask below the modulus), `done` brings `res_lo` = (base^(exp-1) + mask) mod modulus and `res_hi` = (base^exp + mask) mod modulus, with `error` = 0. Both results are then below the modulus.
- R3: A base equal to or larger than the modulus, including all-ones, is reduced first and gives the same results as its residue.
- R4: `done` is high for exactly one cycle. `res_lo`, `res_hi` and `error` keep their values while the block is idle until the next accepted `start`.
- R5: A `start` pulse while a run is in progress is ignored: the results belong to the operands of the first start.
- R6: The cycle count from `start` to `done` is the same for every legal operand set, whatever the exponent bit pattern or base.
- R7: An exponent with bit 0 clear or bit EW-1 clear gives `error` = 1 at `done`.
- R8: If the working exponent changes during a run, so that it differs from the copy taken at start, the run ends with `error` = 1.
- R9: If the loop index is disturbed so that the number of ladder iterations differs from EW-2, the run ends with `error` = 1.
- R10: Whenever `error` is 1, `res_lo` and `res_hi` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run with the present operands, sampled only when idle |
| base | input | W | Base value, any magnitude |
| expo | input | EW | Exponent; bits 0 and EW-1 must be set |
| modulus | input | W | Modulus, at least 2 |
| mask | input | W | Additive mask, below the modulus |
| done | output | 1 | One-cycle pulse when a run ends |
| error | output | 1 | Integrity or input check failed for the last run |
| res_lo | output | W | Masked power for exponent minus one, or 0 on error |
| res_hi | output | W | Masked power for the exponent, or 0 on error |

## Verification
The bench targets operands at the edges of the arithmetic. These are a base above the modulus, a zero base, the smallest modulus of 2, an even modulus, and a mask of modulus minus one that forces the final add to wrap. A design that skipped the initial reduction or the second subtraction in the multiplier would return values at or above the modulus there. Timing is checked by comparing latencies across very different exponents, which a design that skipped work on zero bits would fail. Faults are injected by overriding the working exponent and the loop index in the middle of a run. A design without the shadow copy or the independent count would release wrong powers where it should raise `error`. A design without output gating would leak partial values on error.

// File: rtl/lm_pkg.sv
// Shared types for the ladder exponentiator.
package lm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RED,     // reduce base: 1 * base mod N
        ST_SQ0,     // second ladder register: base squared
        ST_STEP_X,  // cross product into the register not chosen by the bit
        ST_STEP_S,  // square of the register chosen by the bit
        ST_FIN_X,   // closing cross product into the high register
        ST_FIN_S,   // closing square of the low register
        ST_MASK     // mask add, integrity check, release
    } lm_state_e;
endpackage

// File: rtl/lm_modmul.sv
// Serial modular multiplier: p = x * y mod m, one bit of y per cycle, MSB first.
// Assumes x < m and m >= 2; y may take any value. go loads operands, and rdy
// pulses one cycle after the W-th step, with p valid from then until the next go.
module lm_modmul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] m,
    output logic         rdy,
    output logic [W-1:0] p
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc_q, x_q, y_q;
    logic [CW-1:0] cnt_q;
    logic          rdy_q;
    logic [W:0]    dbl, r1, s, r2;
    logic          unused_top;

    // One step: double, reduce, add x when the current bit is set, reduce.
    always_comb begin
        dbl = {acc_q, 1'b0};
        r1  = (dbl >= {1'b0, m}) ? dbl - {1'b0, m} : dbl;
        s   = r1 + (y_q[W-1] ? {1'b0, x_q} : '0);
        r2  = (s >= {1'b0, m}) ? s - {1'b0, m} : s;
    end
    assign unused_top = r2[W];

    // Operand load, bit-serial accumulation and ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            if (go) begin
                acc_q <= '0;
                x_q   <= x;
                y_q   <= y;
                cnt_q <= CW'(W);
            end else if (cnt_q != '0) begin
                acc_q <= r2[W-1:0];
                y_q   <= {y_q[W-2:0], 1'b0};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) rdy_q <= 1'b1;
            end
        end
    end

    assign rdy = rdy_q;
    assign p   = acc_q;
endmodule

// File: rtl/lm_modadd.sv
// Modular adder: r = (a + b) mod m. Assumes a < m and b < m; purely combinational.
module lm_modadd #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] m,
    output logic [W-1:0] r
);
    logic [W:0] s, t;
    logic       unused_top;

    // Add, then subtract the modulus once when the sum reaches it.
    always_comb begin
        s = {1'b0, a} + {1'b0, b};
        t = (s >= {1'b0, m}) ? s - {1'b0, m} : s;
    end
    assign r          = t[W-1:0];
    assign unused_top = t[W];
endmodule

// File: rtl/lm_seq.sv
// Ladder sequencer: holds the two ladder registers, walks the exponent from bit
// EW-2 down to 1 with a fixed cross-then-square order, runs the closing step,
// then checks the shadow exponent, the iteration count and the exponent form
// before releasing masked results. Assumes EW >= 3 and a stable multiplier.
module lm_seq
    import lm_pkg::*;
#(
    parameter int W  = 32,
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  base,
    input  logic [EW-1:0] expo,
    input  logic [W-1:0]  modulus,
    input  logic [W-1:0]  mask,
    input  logic          mul_rdy,
    input  logic [W-1:0]  mul_p,
    input  logic [W-1:0]  sum_lo,
    input  logic [W-1:0]  sum_hi,
    output logic          mul_go,
    output logic [W-1:0]  mul_x,
    output logic [W-1:0]  mul_y,
    output logic [W-1:0]  mod_q,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  a0_q,
    output logic [W-1:0]  a1_q,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [W-1:0]  res_lo,
    output logic [W-1:0]  res_hi
);
    localparam int          IW       = $clog2(EW);
    localparam logic [IW-1:0] IDX_TOP = IW'(EW - 2);
    localparam logic [IW-1:0] ITERS   = IW'(EW - 2);

    lm_state_e     st;
    logic          pend;
    logic [W-1:0]  base_q;
    logic [EW-1:0] exp_work, exp_shadow;
    logic [IW-1:0] idx, iters;
    logic          di, in_mul, bad;

    assign di     = exp_work[idx];
    assign in_mul = (st != ST_IDLE) && (st != ST_MASK);
    assign mul_go = in_mul && !pend;
    assign busy   = (st != ST_IDLE);
    assign bad    = (exp_work != exp_shadow) || (iters != ITERS) ||
                    (idx != IW'(1)) || !exp_shadow[0] || !exp_shadow[EW-1];

    // Operand routing for the product each state performs.
    always_comb begin
        mul_x = '0;
        mul_y = '0;
        case (st)
            ST_RED:    begin mul_x = W'(1);           mul_y = base_q;          end
            ST_SQ0:    begin mul_x = a0_q;            mul_y = a0_q;            end
            ST_STEP_X: begin mul_x = di ? a1_q : a0_q; mul_y = di ? a0_q : a1_q; end
            ST_STEP_S: begin mul_x = di ? a1_q : a0_q; mul_y = di ? a1_q : a0_q; end
            ST_FIN_X:  begin mul_x = a0_q;            mul_y = a1_q;            end
            ST_FIN_S:  begin mul_x = a0_q;            mul_y = a0_q;            end
            default:   begin mul_x = '0;              mul_y = '0;              end
        endcase
    end

    // State walk, ladder register updates, integrity check and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            pend       <= 1'b0;
            base_q     <= '0;
            mod_q      <= '0;
            mask_q     <= '0;
            a0_q       <= '0;
            a1_q       <= '0;
            exp_work   <= '0;
            exp_shadow <= '0;
            idx        <= '0;
            iters      <= '0;
            done       <= 1'b0;
            error      <= 1'b0;
            res_lo     <= '0;
            res_hi     <= '0;
        end else begin
            done <= 1'b0;
            if (mul_go)  pend <= 1'b1;
            if (mul_rdy) pend <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    base_q     <= base;
                    mod_q      <= modulus;
                    mask_q     <= mask;
                    exp_work   <= expo;
                    exp_shadow <= expo;
                    idx        <= IDX_TOP;
                    iters      <= '0;
                    error      <= 1'b0;
                    res_lo     <= '0;
                    res_hi     <= '0;
                    st         <= ST_RED;
                end
                ST_RED: if (mul_rdy) begin
                    a0_q <= mul_p;
                    st   <= ST_SQ0;
                end
                ST_SQ0: if (mul_rdy) begin
                    a1_q <= mul_p;
                    st   <= ST_STEP_X;
                end
                ST_STEP_X: if (mul_rdy) begin
                    if (di) a0_q <= mul_p;
                    else    a1_q <= mul_p;
                    st <= ST_STEP_S;
                end
                ST_STEP_S: if (mul_rdy) begin
                    if (di) a1_q <= mul_p;
                    else    a0_q <= mul_p;
                    iters <= iters + 1'b1;
                    if (idx == IW'(1)) begin
                        st <= ST_FIN_X;
                    end else begin
                        idx <= idx - 1'b1;
                        st  <= ST_STEP_X;
                    end
                end
                ST_FIN_X: if (mul_rdy) begin
                    a1_q <= mul_p;
                    st   <= ST_FIN_S;
                end
                ST_FIN_S: if (mul_rdy) begin
                    a0_q <= mul_p;
                    st   <= ST_MASK;
                end
                ST_MASK: begin
                    done   <= 1'b1;
                    error  <= bad;
                    res_lo <= bad ? '0 : sum_lo;
                    res_hi <= bad ? '0 : sum_hi;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ladder_modexp.sv
// Top of the fault-checked ladder exponentiator: one sequencer, one shared
// serial multiplier, and one mask adder per ladder register.
// Assumes EW >= 3, modulus >= 2 and mask < modulus.
module ladder_modexp #(
    parameter int W  = 32,
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  base,
    input  logic [EW-1:0] expo,
    input  logic [W-1:0]  modulus,
    input  logic [W-1:0]  mask,
    output logic          done,
    output logic          error,
    output logic [W-1:0]  res_lo,
    output logic [W-1:0]  res_hi
);
    logic         mul_go, mul_rdy, busy;
    logic [W-1:0] mul_x, mul_y, mul_p, mod_q, mask_q;
    logic [W-1:0] ladder [2];
    logic [W-1:0] masked [2];

    lm_seq #(.W(W), .EW(EW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base(base), .expo(expo), .modulus(modulus), .mask(mask),
        .mul_rdy(mul_rdy), .mul_p(mul_p),
        .sum_lo(masked[0]), .sum_hi(masked[1]),
        .mul_go(mul_go), .mul_x(mul_x), .mul_y(mul_y),
        .mod_q(mod_q), .mask_q(mask_q),
        .a0_q(ladder[0]), .a1_q(ladder[1]),
        .busy(busy), .done(done), .error(error),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    lm_modmul #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(mul_go),
        .x(mul_x), .y(mul_y), .m(mod_q),
        .rdy(mul_rdy), .p(mul_p)
    );

    // One mask adder per ladder register.
    for (genvar g = 0; g < 2; g++) begin : g_mask
        lm_modadd #(.W(W)) u_add (
            .a(ladder[g]), .b(mask_q), .m(mod_q), .r(masked[g])
        );
    end
endmodule

// File: rtl/ladder_modexp_chk.sv
// Protocol and output-gating assertions for ladder_modexp, attached by bind.
module ladder_modexp_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         error,
    input logic [W-1:0] res_lo,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] mod_q
);
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_lo) && $stable(res_hi) && $stable(error)));

    p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (res_lo < mod_q && res_hi < mod_q));

    p_error_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);

    p_zero_on_error_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (res_lo == '0 && res_hi == '0));

    p_start_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
endmodule

bind ladder_modexp ladder_modexp_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .res_lo(res_lo), .res_hi(res_hi), .mod_q(mod_q)
);

// File: tb/ladder_modexp_tb.sv
module ladder_modexp_tb;
    localparam int W     = 32;
    localparam int EW    = 32;
    localparam int LIMIT = 6000;
    localparam int NV    = 7;

    // {base, exponent, modulus, mask}
    localparam logic [127:0] VEC [NV] = '{
        {32'd5,          32'h8000_0001, 32'd1000003,    32'd0},
        {32'hFFFF_FFFF,  32'hFFFF_FFFF, 32'hFFFF_FFFB,  32'd7},
        {32'd2,          32'hA5A5_A5A5, 32'h7FFF_FFFF,  32'h7FFF_FFFE},
        {32'd0,          32'h8000_0003, 32'd97,         32'd13},
        {32'd123456789,  32'hC000_0001, 32'd2,          32'd1},
        {32'd1,          32'h8765_4321, 32'h8000_0000,  32'd5},
        {32'd3,          32'hF0F0_0F0F, 32'd65537,      32'd65536}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  base = '0, modulus = '0, mask = '0;
    logic [EW-1:0] expo = '0;
    logic          done, error;
    logic [W-1:0]  res_lo, res_hi;

    int errs = 0;
    int checks = 0;
    int lat0 = 0;

    always #10 clk = ~clk;

    ladder_modexp #(.W(W), .EW(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .expo(expo),
        .modulus(modulus), .mask(mask), .done(done), .error(error),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    function automatic logic [31:0] pw(input logic [31:0] b, input logic [31:0] e,
                                       input logic [31:0] n);
        longint unsigned r, bb, nn;
        nn = {32'd0, n};
        bb = {32'd0, b} % nn;
        r  = 64'd1 % nn;
        for (int i = 31; i >= 0; i--) begin
            r = (r * r) % nn;
            if (e[i]) r = (r * bb) % nn;
        end
        return r[31:0];
    endfunction

    function automatic logic [31:0] addm(input logic [31:0] v, input logic [31:0] a,
                                         input logic [31:0] n);
        longint unsigned s;
        s = ({32'd0, v} + {32'd0, a}) % {32'd0, n};
        return s[31:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode 0 plain, 1 second start mid-run, 2 exponent fault, 3 index fault
    task automatic run(input logic [31:0] b, input logic [31:0] e, input logic [31:0] n,
                       input logic [31:0] a, input int mode, output int cyc);
        @(negedge clk);
        base = b; expo = e; modulus = n; mask = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (cyc == 200) begin
                if (mode == 1) begin
                    base = 32'd9; expo = 32'h8000_0005; modulus = 32'd1009;
                    mask = 32'd3; start = 1'b1;
                end
                if (mode == 2) force u_dut.u_seq.exp_work = e ^ 32'h0000_0100;
                if (mode == 3) force u_dut.u_seq.idx = 5'd1;
            end
            if (cyc == 201) begin
                start = 1'b0;
                if (mode == 2) release u_dut.u_seq.exp_work;
                if (mode == 3) release u_dut.u_seq.idx;
            end
        end
        if (!done) chk(1'b0, "R6 run timeout", 32'(cyc), 32'(LIMIT));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL R6 watchdog actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] b, e, n, a, elo, ehi, hold_lo;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done", 32'(done), 0);
        chk(error == 1'b0, "R1 error", 32'(error), 0);
        chk(res_lo == '0, "R1 res_lo", res_lo, 0);
        chk(res_hi == '0, "R1 res_hi", res_hi, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R3, R6: vector walk
        for (int k = 0; k < NV; k++) begin
            b = VEC[k][127:96]; e = VEC[k][95:64]; n = VEC[k][63:32]; a = VEC[k][31:0];
            elo = addm(pw(b, e - 1, n), a, n);
            ehi = addm(pw(b, e, n), a, n);
            run(b, e, n, a, 0, cyc);
            chk(res_lo == elo, "R2 res_lo", res_lo, elo);
            chk(res_hi == ehi, "R2 res_hi", res_hi, ehi);
            chk(error == 1'b0, "R2 error", 32'(error), 0);
            if (k == 1) chk(res_hi == ehi, "R3 base above modulus", res_hi, ehi);
            if (k == 0) lat0 = cyc;
            else chk(cyc == lat0, "R6 latency", 32'(cyc), 32'(lat0));
            // R4: single-cycle done, results held while idle
            hold_lo = res_lo;
            @(negedge clk);
            chk(done == 1'b0, "R4 done pulse", 32'(done), 0);
            repeat (3) @(negedge clk);
            chk(res_lo == hold_lo, "R4 hold", res_lo, hold_lo);
        end

        // R5: start during a run is ignored
        b = 32'd7; e = 32'h9000_000B; n = 32'd1000003; a = 32'd11;
        run(b, e, n, a, 1, cyc);
        ehi = addm(pw(b, e, n), a, n);
        elo = addm(pw(b, e - 1, n), a, n);
        chk(res_hi == ehi, "R5 res_hi", res_hi, ehi);
        chk(res_lo == elo, "R5 res_lo", res_lo, elo);
        chk(cyc == lat0, "R5 latency", 32'(cyc), 32'(lat0));

        // R7, R10: illegal exponent forms
        run(32'd5, 32'h8000_0002, 32'd97, 32'd1, 0, cyc);
        chk(error == 1'b1, "R7 even exponent", 32'(error), 1);
        chk(res_lo == '0 && res_hi == '0, "R10 zero on error", res_lo | res_hi, 0);
        run(32'd5, 32'h4000_0001, 32'd97, 32'd1, 0, cyc);
        chk(error == 1'b1, "R7 top bit clear", 32'(error), 1);
        chk(res_hi == '0, "R10 zero on error", res_hi, 0);

        // R8: working exponent disturbed mid-run
        run(32'd3, 32'hF0F0_0F0F, 32'd65537, 32'd2, 2, cyc);
        chk(error == 1'b1, "R8 exponent fault", 32'(error), 1);
        chk(res_lo == '0, "R10 zero on error", res_lo, 0);

        // R9: loop index disturbed mid-run
        run(32'd3, 32'hF0F0_0F0F, 32'd65537, 32'd2, 3, cyc);
        chk(error == 1'b1, "R9 index fault", 32'(error), 1);
        chk(res_hi == '0, "R10 zero on error", res_hi, 0);

        // R2: clean run after errors
        run(32'd5, 32'h8000_0001, 32'd1000003, 32'd0, 0, cyc);
        ehi = pw(32'd5, 32'h8000_0001, 32'd1000003);
        chk(error == 1'b0 && res_hi == ehi, "R2 recovery", res_hi, ehi);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule